// File: doc/BRIEF.md
# UART Receive FIFO with Per-Byte Error Tagging

This block sits between a UART's serial receiver and its register interface. Every byte that the receiver delivers is written into a 16-entry queue. The framing, parity and break indications that came with that byte are stored in the same entry. The status bits are taken from the entry at the head of the queue. Software that reads the line status before each buffer read therefore sees the errors of exactly the byte that the next buffer read will return.

The block also keeps a count of how many stored entries carry an error. While that count is non-zero, a summary error bit is set and the DMA request is held low. A DMA engine then never drains a faulty byte unnoticed. Software removes the faulty bytes by alternating status and buffer reads, or it empties the whole queue with a clear strobe. After that, the DMA request comes back for the clean data that remains.

A two-bit field selects the occupancy at which the receive interrupt is raised. If a byte arrives while the queue is full, that byte is dropped and an overrun flag is latched.

Top module: `uart_rx_errfifo`

## Requirements
- R1: Bytes are returned in arrival order. `rbr_data` shows the popped byte in the cycle after a `buf_rd` pulse on a non-empty queue.
- R2: `lsr_frm`, `lsr_par` and `lsr_brk` show the flags of the head entry only, and all three are 0 while the queue is empty.
- R3: `data_ready` is 1 exactly when at least one entry is stored.
- R4: `trig_sel` encodes the receive threshold as 0→1, 1→4, 2→8 and 3→14 entries. `rx_irq` is 1 while the occupancy is at or above the threshold.
- R5: `err_sum` is 1 while any stored entry carries a framing, parity or break flag. It falls once the last such entry has been read out.
- R6: `dma_req` is 1 exactly when `rx_irq` is 1 and `err_sum` is 0.
- R7: A `buf_rd` pulse on an empty queue leaves `rbr_data` unchanged and moves no pointer.
- R8: A byte pushed while 16 entries are stored is discarded and sets `lsr_ovr`. `lsr_ovr` stays set until a `stat_rd` pulse. If a drop and a `stat_rd` pulse happen in the same cycle, the flag stays set.
- R9: A `fifo_clr` pulse empties both the data entries and the error count in the next cycle. A push or buffer read in the same cycle is ignored.
- R10: After reset the queue is empty, all flags are 0 and `rbr_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receiver byte-valid strobe |
| rx_data | input | 8 | Received byte |
| rx_frm_err | input | 1 | Framing error for this byte |
| rx_par_err | input | 1 | Parity error for this byte |
| rx_brk | input | 1 | Break detected for this byte |
| stat_rd | input | 1 | Line status register read strobe |
| buf_rd | input | 1 | Receive buffer register read strobe (pops one entry) |
| fifo_clr | input | 1 | FIFO-control clear strobe |
| trig_sel | input | 2 | Receive trigger level select |
| data_ready | output | 1 | Queue not empty |
| err_sum | output | 1 | Some stored entry carries an error |
| rx_irq | output | 1 | Occupancy at or above trigger level |
| dma_req | output | 1 | Receive DMA request |
| lsr_frm | output | 1 | Framing flag of head entry |
| lsr_par | output | 1 | Parity flag of head entry |
| lsr_brk | output | 1 | Break flag of head entry |
| lsr_ovr | output | 1 | Overrun flag |
| rbr_data | output | 8 | Last byte read from the buffer |

## Verification
The main pattern is a mixed burst of eight bytes. Clean entries sit between entries that carry a single parity, framing or break error and one entry that carries two errors. Draining this burst shows whether the status flags follow the head entry rather than the newest push. It also shows whether the summary bit falls right after the last faulty byte leaves, and not earlier or later. A second pattern puts one faulty byte in front of clean ones. It separates a DMA request that is blocked for the right reason from one that stays blocked. Fill sweeps for each threshold code, a fill past capacity, reads on an empty queue and a clear with faulty bytes inside cover the edges of the threshold, overrun, empty-read and clear rules.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
    localparam int unsigned DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic entry_bad(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction
endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          clr,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] fill,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          drop
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    full, empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = push_req && !full && !clr;
        pop_ok  = pop_req && !empty && !clr;
        drop    = push_req && full && !clr;
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = bump(st_q.wr);
            if (pop_ok)  st_d.rd = bump(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign fill   = st_q.cnt;
endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import uart_rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     wptr,
    input  rx_entry_t         wentry,
    input  logic [AW-1:0]     rptr,
    input  logic              pop_ok,
    output rx_entry_t         head,
    output logic [DATA_W-1:0] rbr
);
    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [DATA_W-1:0]     rbr;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        head = st_q.mem[rptr];
        st_d = st_q;
        if (we)     st_d.mem[wptr] = wentry;
        if (pop_ok) st_d.rbr = head.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rbr = st_q.rbr;
endmodule

// File: rtl/rxf_err_track.sv
module rxf_err_track #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_ok,
    input  logic push_bad,
    input  logic pop_ok,
    input  logic pop_bad,
    input  logic clr,
    input  logic drop,
    input  logic stat_rd,
    output logic err_any,
    output logic ovr
);
    typedef struct packed {
        logic [CW-1:0] bad_cnt;
        logic          ovr;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.bad_cnt = '0;
        else
            st_d.bad_cnt = st_q.bad_cnt + CW'(push_ok && push_bad)
                                        - CW'(pop_ok && pop_bad);
        if (drop)         st_d.ovr = 1'b1;
        else if (stat_rd) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_any = (st_q.bad_cnt != '0);
    assign ovr     = st_q.ovr;
endmodule

// File: rtl/rxf_req_gen.sv
module rxf_req_gen #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] fill,
    input  logic [1:0]    trig_sel,
    input  logic          err_any,
    output logic          irq,
    output logic          dma
);
    logic [CW-1:0] thr;

    always_comb begin
        case (trig_sel)
            2'd0:    thr = CW'(1);
            2'd1:    thr = CW'(DEPTH / 4);
            2'd2:    thr = CW'(DEPTH / 2);
            default: thr = CW'(DEPTH - 2);
        endcase
        irq = (fill >= thr);
        dma = irq && !err_any;
    end
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import uart_rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    input  logic       rx_frm_err,
    input  logic       rx_par_err,
    input  logic       rx_brk,
    input  logic       stat_rd,
    input  logic       buf_rd,
    input  logic       fifo_clr,
    input  logic [1:0] trig_sel,
    output logic       data_ready,
    output logic       err_sum,
    output logic       rx_irq,
    output logic       dma_req,
    output logic       lsr_frm,
    output logic       lsr_par,
    output logic       lsr_brk,
    output logic       lsr_ovr,
    output logic [7:0] rbr_data
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill_lvl;
    logic          push_ok, pop_ok, drop;
    rx_entry_t     in_entry, head;

    assign in_entry = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_data};

    rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push_req(rx_push), .pop_req(buf_rd),
        .clr(fifo_clr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill_lvl),
        .push_ok(push_ok), .pop_ok(pop_ok), .drop(drop)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(push_ok), .wptr(wr_ptr),
        .wentry(in_entry), .rptr(rd_ptr), .pop_ok(pop_ok),
        .head(head), .rbr(rbr_data)
    );

    rxf_err_track #(.DEPTH(DEPTH)) u_err (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok),
        .push_bad(entry_bad(in_entry)), .pop_ok(pop_ok),
        .pop_bad(entry_bad(head)), .clr(fifo_clr), .drop(drop),
        .stat_rd(stat_rd), .err_any(err_sum), .ovr(lsr_ovr)
    );

    rxf_req_gen #(.DEPTH(DEPTH)) u_req (
        .fill(fill_lvl), .trig_sel(trig_sel), .err_any(err_sum),
        .irq(rx_irq), .dma(dma_req)
    );

    assign data_ready = (fill_lvl != '0);
    assign lsr_frm    = data_ready && head.frm;
    assign lsr_par    = data_ready && head.par;
    assign lsr_brk    = data_ready && head.brk;
endmodule

// File: rtl/uart_rxf_chk.sv
module uart_rxf_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          buf_rd,
    input logic          fifo_clr,
    input logic          data_ready,
    input logic          err_sum,
    input logic          rx_irq,
    input logic          dma_req,
    input logic          lsr_frm,
    input logic          lsr_par,
    input logic          lsr_brk,
    input logic          lsr_ovr,
    input logic [7:0]    rbr_data,
    input logic [CW-1:0] fill_lvl
);
    a_r6_dma_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> !dma_req);
    a_r6_dma_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> rx_irq);
    a_r2_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> !(lsr_frm || lsr_par || lsr_brk));
    a_r5_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> data_ready);
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!data_ready && !err_sum));
    a_r7_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !data_ready) |=> $stable(rbr_data));
    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !fifo_clr && fill_lvl == CW'(DEPTH)) |=> lsr_ovr);
    a_r8_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == CW'(DEPTH) && !buf_rd && !fifo_clr) |=> (fill_lvl == CW'(DEPTH)));
endmodule

bind uart_rx_errfifo uart_rxf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .buf_rd(buf_rd),
    .fifo_clr(fifo_clr), .data_ready(data_ready), .err_sum(err_sum),
    .rx_irq(rx_irq), .dma_req(dma_req), .lsr_frm(lsr_frm),
    .lsr_par(lsr_par), .lsr_brk(lsr_brk), .lsr_ovr(lsr_ovr),
    .rbr_data(rbr_data), .fill_lvl(fill_lvl)
);

// File: tb/uart_rx_errfifo_tb.sv
module uart_rx_errfifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_frm_err = 0, rx_par_err = 0, rx_brk = 0;
    logic [7:0] rx_data = 0;
    logic       stat_rd = 0, buf_rd = 0, fifo_clr = 0;
    logic [1:0] trig_sel = 0;
    logic       data_ready, err_sum, rx_irq, dma_req;
    logic       lsr_frm, lsr_par, lsr_brk, lsr_ovr;
    logic [7:0] rbr_data;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    uart_rx_errfifo u_dut (.*);

    // {brk, frm, par, data}
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 8'h11}, {3'b001, 8'h22}, {3'b000, 8'h33}, {3'b010, 8'h44},
        {3'b100, 8'h55}, {3'b000, 8'h66}, {3'b011, 8'h77}, {3'b000, 8'h88}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        rx_push = 1; rx_data = d; {rx_brk, rx_frm_err, rx_par_err} = e;
        @(negedge clk);
        rx_push = 0; {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
    endtask

    task automatic rd_buf();
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic rd_stat();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic clear();
        @(negedge clk); fifo_clr = 1;
        @(negedge clk); fifo_clr = 0;
    endtask

    initial begin
        #(20ns * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 ready", data_ready, 0);
        chk("R10 err", err_sum, 0);
        chk("R10 irq/dma", {rx_irq, dma_req}, 0);
        chk("R10 flags", {lsr_frm, lsr_par, lsr_brk, lsr_ovr}, 0);
        chk("R10 rbr", rbr_data, 0);

        // Table walk: R1 R2 R3 R5 with threshold 8 (code 2)
        trig_sel = 2'd2;
        for (int i = 0; i < 8; i++) push(VEC[i][7:0], VEC[i][10:8]);
        chk("R4 irq at 8", rx_irq, 1);
        chk("R6 dma held by error", dma_req, 0);
        for (int i = 0; i < 8; i++) begin
            logic exp_err;
            exp_err = 0;
            for (int j = i; j < 8; j++) exp_err |= |VEC[j][10:8];
            chk("R3 ready before read", data_ready, 1);
            chk("R2 head flags", {lsr_brk, lsr_frm, lsr_par}, VEC[i][10:8]);
            chk("R5 err summary", err_sum, exp_err);
            rd_stat();
            rd_buf();
            chk("R1 order", rbr_data, VEC[i][7:0]);
        end
        chk("R3 empty after drain", data_ready, 0);
        chk("R5 err clear after drain", err_sum, 0);

        // R7 empty read keeps last value
        rd_buf();
        chk("R7 empty read rbr", rbr_data, 8'h88);
        push(8'hA5, 3'b000);
        rd_buf();
        chk("R7 pointer unmoved", rbr_data, 8'hA5);

        // R6 DMA re-enabled once faulty head is gone (threshold 4, code 1)
        trig_sel = 2'd1;
        push(8'hB0, 3'b010);
        for (int i = 1; i < 6; i++) push(8'hB0 + 8'(i), 3'b000);
        chk("R6 irq, dma blocked", {rx_irq, dma_req}, 2'b10);
        rd_buf();
        chk("R6 dma re-enabled", {err_sum, dma_req}, 2'b01);
        chk("R1 faulty byte out", rbr_data, 8'hB0);

        // R9 clear with faulty bytes present
        push(8'hC1, 3'b100);
        clear();
        chk("R9 empty", data_ready, 0);
        chk("R9 err count cleared", err_sum, 0);
        chk("R9 flags", {lsr_frm, lsr_par, lsr_brk}, 0);
        push(8'hC2, 3'b000);
        rd_buf();
        chk("R9 no stale entries", rbr_data, 8'hC2);

        // R4 threshold sweep
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            clear();
            trig_sel = 2'(s);
            for (int k = 0; k < lvl - 1; k++) push(8'(k), 3'b000);
            chk($sformatf("R4 below level code %0d", s), rx_irq, 0);
            push(8'hFF, 3'b000);
            chk($sformatf("R4 at level code %0d", s), {rx_irq, dma_req}, 2'b11);
        end

        // R8 overrun
        clear();
        trig_sel = 2'd3;
        for (int k = 0; k < 16; k++) push(8'h40 + 8'(k), 3'b000);
        chk("R8 no overrun at full", lsr_ovr, 0);
        push(8'hEE, 3'b000);
        chk("R8 overrun set", lsr_ovr, 1);
        for (int k = 0; k < 16; k++) begin
            rd_buf();
            chk("R8 kept bytes", rbr_data, 8'h40 + 8'(k));
        end
        chk("R8 dropped byte absent", data_ready, 0);
        chk("R8 overrun sticky", lsr_ovr, 1);
        rd_stat();
        chk("R8 overrun cleared by status read", lsr_ovr, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule